// File: doc/BRIEF.md
# Floppy Data Rate Control Register

This block is the write-only rate and precompensation control register of a floppy disk controller. A CPU write to its decoded I/O address stores a data-rate code, a write-precompensation code and a manual low-power request, and can fire a software reset of the rest of the controller. A second configuration-control register may also set the data rate. The rate that the controller uses is taken from whichever of the two was written last.

The stored precompensation code is turned into a write delay, counted in fine steps of about 20.83 ns. The length of each step depends on whether the external 2 Mbps mode is active. A separate configure input loads the starting track. The block flags whether precompensation applies to the track the head is on. Low-power mode ends when software touches the data register or the main status register, or when the register is written with the reset bit set.

Top module: `fdc_rate_ctl`

## Requirements
- R1: After hardware reset (rst_ni low), rate_o is 2'b10 (250 kbps), the stored precompensation code is 3'b000, lowpwr_o and soft_rst_o are 0, and the precompensation start track is 0.
- R2: Only a write with wr_i high and addr_i equal to DSR_ADDR (default 0x3F4) changes the register. Writes to any other address leave every output unchanged. The register has no read path.
- R3: rate_o follows the most recent write. A register write loads wdata_i[1:0] and a ccr_wr_i strobe loads ccr_rate_i. When both happen in the same cycle, the register write wins. The new rate appears on the clock edge that takes the write.
- R4: The precompensation code is wdata_i[4:2]. Code 3'b111 gives 0 steps and codes 3'b001 to 3'b110 give 1 to 6 steps. Code 3'b000 gives 3 steps when fast_mode_i is 0 and 1 step when fast_mode_i is 1. precomp_dly_o equals the step count times 2 when fast_mode_i is 0, and the step count when it is 1.
- R5: wdata_i[5] has no effect on any output.
- R6: A register write loads lowpwr_o from wdata_i[6]. Without such a write, a data_acc_i or msr_acc_i pulse clears lowpwr_o on the next edge. A register write with wdata_i[6] set and wdata_i[7] clear takes priority over an access in the same cycle.
- R7: A register write with wdata_i[7] set drives soft_rst_o high for exactly the one cycle after the write edge and clears lowpwr_o. The rate and precompensation fields of that write are stored as usual.
- R8: precomp_en_o is 1 exactly when track_i is at or above the start track. The start track is loaded from start_trk_i on a clock edge where start_trk_we_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| addr_i | input | ADDR_W | CPU I/O address |
| wr_i | input | 1 | CPU write strobe |
| wdata_i | input | 8 | CPU write data |
| ccr_wr_i | input | 1 | Configuration-control register rate write |
| ccr_rate_i | input | 2 | Rate code from the configuration-control write |
| data_acc_i | input | 1 | Access to the data register |
| msr_acc_i | input | 1 | Access to the main status register |
| fast_mode_i | input | 1 | 2 Mbps mode active |
| track_i | input | TRK_W | Current track |
| start_trk_we_i | input | 1 | Configure command loads the start track |
| start_trk_i | input | TRK_W | New precompensation start track |
| rate_o | output | 2 | Effective data-rate code |
| precomp_dly_o | output | 4 | Precompensation delay in 20.83 ns units |
| precomp_en_o | output | 1 | Precompensation applies to the current track |
| lowpwr_o | output | 1 | Manual low-power mode |
| soft_rst_o | output | 1 | One-cycle software reset pulse |

## Verification
The hardest cases to reach are the ones where several sources act on the same clock edge. These are a register write and a configuration-control write landing together, and a low-power set arriving with a data or status access. A low-power set that also carries the reset bit is a third. The bench drives each of these collisions on purpose and compares against a behavioural model on every clock. The model is also checked against all eight precompensation codes in both rate modes, and the start track is moved across the current track.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  localparam logic [1:0] RATE_RST   = 2'b10;
  localparam logic [2:0] PC_DEFAULT = 3'b000;
  localparam logic [2:0] PC_NONE    = 3'b111;
  localparam int unsigned DEF_STEPS_SLOW = 3;
  localparam int unsigned DEF_STEPS_FAST = 1;
  localparam int unsigned FINE_PER_SLOW  = 2;
  localparam int unsigned MAX_STEPS      = 6;
  localparam int unsigned DLY_W = $clog2(MAX_STEPS * FINE_PER_SLOW + 1);

  typedef struct packed {
    logic       srst;
    logic       lp;
    logic       spare;
    logic [2:0] pc;
    logic [1:0] rate;
  } ctl_word_t;
endpackage

// File: rtl/fdc_ctl_regs.sv
module fdc_ctl_regs
  import fdc_rate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  ctl_word_t  word_i,
  input  logic       data_acc_i,
  input  logic       msr_acc_i,
  output logic [2:0] pc_o,
  output logic       lp_o,
  output logic       srst_o
);
  logic [2:0] pc_q;
  logic       lp_q, srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= PC_DEFAULT;
      lp_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= we_i && word_i.srst;
      if (we_i) begin
        pc_q <= word_i.pc;
        lp_q <= word_i.lp && !word_i.srst;
      end else if (data_acc_i || msr_acc_i) begin
        lp_q <= 1'b0;
      end
    end
  end

  assign pc_o   = pc_q;
  assign lp_o   = lp_q;
  assign srst_o = srst_q;
endmodule

// File: rtl/fdc_rate_arb.sv
module fdc_rate_arb
  import fdc_rate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dsr_we_i,
  input  logic [1:0] dsr_rate_i,
  input  logic       ccr_we_i,
  input  logic [1:0] ccr_rate_i,
  output logic [1:0] rate_o
);
  logic [1:0] rate_q;

  // last writer wins, register write over ccr on a tie
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rate_q <= RATE_RST;
    else if (dsr_we_i) rate_q <= dsr_rate_i;
    else if (ccr_we_i) rate_q <= ccr_rate_i;
  end

  assign rate_o = rate_q;
endmodule

// File: rtl/fdc_precomp_map.sv
module fdc_precomp_map
  import fdc_rate_pkg::*;
#(
  parameter int unsigned TRK_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       pc_i,
  input  logic             fast_i,
  input  logic [TRK_W-1:0] track_i,
  input  logic             start_we_i,
  input  logic [TRK_W-1:0] start_i,
  output logic [DLY_W-1:0] dly_o,
  output logic             en_o
);
  logic [TRK_W-1:0] start_q;
  logic [2:0]       steps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         start_q <= '0;
    else if (start_we_i) start_q <= start_i;
  end

  always_comb begin
    unique case (pc_i)
      PC_NONE:    steps = 3'd0;
      PC_DEFAULT: steps = fast_i ? 3'(DEF_STEPS_FAST) : 3'(DEF_STEPS_SLOW);
      default:    steps = pc_i;
    endcase
  end

  assign dly_o = fast_i ? DLY_W'(steps) : DLY_W'(steps) * DLY_W'(FINE_PER_SLOW);
  assign en_o  = track_i >= start_q;
endmodule

// File: rtl/fdc_rate_ctl.sv
module fdc_rate_ctl
  import fdc_rate_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] DSR_ADDR = 10'h3F4,
  parameter int unsigned       TRK_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             ccr_wr_i,
  input  logic [1:0]       ccr_rate_i,
  input  logic             data_acc_i,
  input  logic             msr_acc_i,
  input  logic             fast_mode_i,
  input  logic [TRK_W-1:0] track_i,
  input  logic             start_trk_we_i,
  input  logic [TRK_W-1:0] start_trk_i,
  output logic [1:0]       rate_o,
  output logic [DLY_W-1:0] precomp_dly_o,
  output logic             precomp_en_o,
  output logic             lowpwr_o,
  output logic             soft_rst_o
);
  logic       dsr_we;
  ctl_word_t  word;
  logic [2:0] pc;

  assign dsr_we = wr_i && (addr_i == DSR_ADDR);
  assign word   = ctl_word_t'(wdata_i);

  fdc_ctl_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (dsr_we),
    .word_i    (word),
    .data_acc_i(data_acc_i),
    .msr_acc_i (msr_acc_i),
    .pc_o      (pc),
    .lp_o      (lowpwr_o),
    .srst_o    (soft_rst_o)
  );

  fdc_rate_arb i_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dsr_we_i  (dsr_we),
    .dsr_rate_i(word.rate),
    .ccr_we_i  (ccr_wr_i),
    .ccr_rate_i(ccr_rate_i),
    .rate_o    (rate_o)
  );

  fdc_precomp_map #(.TRK_W(TRK_W)) i_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pc_i      (pc),
    .fast_i    (fast_mode_i),
    .track_i   (track_i),
    .start_we_i(start_trk_we_i),
    .start_i   (start_trk_i),
    .dly_o     (precomp_dly_o),
    .en_o      (precomp_en_o)
  );
endmodule

// File: rtl/fdc_rate_ctl_chk.sv
module fdc_rate_ctl_chk
  import fdc_rate_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] DSR_ADDR = 10'h3F4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [7:0]        wdata_i,
  input logic              ccr_wr_i,
  input logic [1:0]        ccr_rate_i,
  input logic              data_acc_i,
  input logic              msr_acc_i,
  input logic [1:0]        rate_o,
  input logic [DLY_W-1:0]  precomp_dly_o,
  input logic              lowpwr_o,
  input logic              soft_rst_o
);
  logic hit;
  assign hit = wr_i && (addr_i == DSR_ADDR);

  // R7
  srst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o || $past(hit && wdata_i[7]));
  // R7
  srst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_o) |-> $past(hit && wdata_i[7]));
  // R7
  srst_lp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> !lowpwr_o);
  // R6
  lp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_acc_i || msr_acc_i) && !hit) |=> !lowpwr_o);
  // R3
  ccr_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccr_wr_i && !hit) |=> rate_o == $past(ccr_rate_i));
  // R2
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit && !ccr_wr_i) |=> $stable(rate_o));
  // R4
  always_comb dly_range_chk: assert (precomp_dly_o <= DLY_W'(MAX_STEPS * FINE_PER_SLOW));
endmodule

bind fdc_rate_ctl fdc_rate_ctl_chk #(.ADDR_W(ADDR_W), .DSR_ADDR(DSR_ADDR)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .ccr_wr_i(ccr_wr_i), .ccr_rate_i(ccr_rate_i), .data_acc_i(data_acc_i),
  .msr_acc_i(msr_acc_i), .rate_o(rate_o), .precomp_dly_o(precomp_dly_o),
  .lowpwr_o(lowpwr_o), .soft_rst_o(soft_rst_o)
);

// File: tb/test_fdc_rate_ctl.sv
`timescale 1ns/1ps
module test_fdc_rate_ctl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       ccr_wr_i = 1'b0;
  logic [1:0] ccr_rate_i = '0;
  logic       data_acc_i = 1'b0;
  logic       msr_acc_i = 1'b0;
  logic       fast_mode_i = 1'b0;
  logic [7:0] track_i = '0;
  logic       start_trk_we_i = 1'b0;
  logic [7:0] start_trk_i = '0;
  logic [1:0] rate_o;
  logic [3:0] precomp_dly_o;
  logic       precomp_en_o, lowpwr_o, soft_rst_o;

  int n_run = 0, n_fail = 0;
  int m_rate = 2, m_pc = 0, m_lp = 0, m_srst = 0, m_start = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  fdc_rate_ctl i_fdc_rate_ctl (.*);

  function automatic int exp_dly();
    int s;
    if (m_pc == 7)      s = 0;
    else if (m_pc == 0) s = fast_mode_i ? 1 : 3;
    else                s = m_pc;
    return fast_mode_i ? s : 2 * s;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rate", rate_o, m_rate);
    chk(tag, "dly", precomp_dly_o, exp_dly());
    chk(tag, "en", precomp_en_o, int'(track_i) >= m_start);
    chk(tag, "lp", lowpwr_o, m_lp);
    chk(tag, "srst", soft_rst_o, m_srst);
  endtask

  task automatic cyc(string tag);
    bit hit;
    @(posedge clk_i);
    hit = wr_i && addr_i == 10'h3F4;
    if (hit) m_rate = wdata_i[1:0];
    else if (ccr_wr_i) m_rate = ccr_rate_i;
    if (hit) m_pc = wdata_i[4:2];
    if (hit) m_lp = wdata_i[7] ? 0 : wdata_i[6];
    else if (data_acc_i || msr_acc_i) m_lp = 0;
    m_srst = hit && wdata_i[7];
    if (start_trk_we_i) m_start = start_trk_i;
    @(negedge clk_i);
    compare(tag);
    wr_i = 0; ccr_wr_i = 0; data_acc_i = 0; msr_acc_i = 0; start_trk_we_i = 0;
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    addr_i = a; wr_i = 1; wdata_i = d;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    compare("R1");
    rst_ni = 1;
    cyc("R1");
    // R2: decoded write, rate 00, code 001
    wr(10'h3F4, 8'b0000_0100); cyc("R2");
    wr(10'h3F5, 8'hFF); cyc("R2");
    wr(10'h0F4, 8'h7B); cyc("R2");
    // R3: ccr then dsr, then tie
    ccr_wr_i = 1; ccr_rate_i = 2'b11; cyc("R3");
    wr(10'h3F4, 8'b0000_1001); cyc("R3");
    ccr_wr_i = 1; ccr_rate_i = 2'b00; wr(10'h3F4, 8'b0000_1010); cyc("R3");
    ccr_wr_i = 1; ccr_rate_i = 2'b01; cyc("R3");
    // R4: all codes both modes
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 8; c++) begin
        fast_mode_i = f[0];
        wr(10'h3F4, {3'b000, c[2:0], 2'b01}); cyc("R4");
      end
    end
    fast_mode_i = 0;
    // R5: spare bit ignored
    wr(10'h3F4, 8'b0010_1110); cyc("R5");
    wr(10'h3F4, 8'b0000_1110); cyc("R5");
    // R6
    wr(10'h3F4, 8'h40); cyc("R6");
    cyc("R6");
    data_acc_i = 1; cyc("R6");
    wr(10'h3F4, 8'h42); cyc("R6");
    msr_acc_i = 1; cyc("R6");
    wr(10'h3F4, 8'h40); data_acc_i = 1; cyc("R6");
    wr(10'h3F4, 8'h00); cyc("R6");
    wr(10'h3F4, 8'h40); msr_acc_i = 1; cyc("R6");
    // R7: reset bit pulses, clears lp, stores fields
    wr(10'h3F4, 8'hC7); cyc("R7");
    cyc("R7");
    wr(10'h3F4, 8'h80); cyc("R7");
    wr(10'h3F4, 8'h80); cyc("R7");
    cyc("R7");
    // R8
    track_i = 8'd3; cyc("R8");
    start_trk_we_i = 1; start_trk_i = 8'd5; cyc("R8");
    track_i = 8'd4; cyc("R8");
    track_i = 8'd5; cyc("R8");
    track_i = 8'd200; cyc("R8");
    start_trk_we_i = 1; start_trk_i = 8'd255; cyc("R8");
    track_i = 8'd255; cyc("R8");
    start_trk_we_i = 1; start_trk_i = 8'd0; track_i = 8'd0; cyc("R8");
    // R1: hardware reset mid-run
    wr(10'h3F4, 8'h5F); cyc("R1");
    rst_ni = 0; m_rate = 2; m_pc = 0; m_lp = 0; m_srst = 0; m_start = 0;
    #1 compare("R1");
    @(negedge clk_i); rst_ni = 1;
    cyc("R1");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule